// File: doc/BRIEF.md
# Reservation-Station Scheduler with Tagged Result Bus

This block is a small out-of-order execution core for register-to-register integer arithmetic. Instructions enter one at a time, in program order, through an issue port guarded by a ready signal. Each one is placed in a free reservation station of its class. Add and subtract use the adder stations. Multiply and divide use the multiplier stations. A per-register status table renames each source operand. The station receives either the register's value or the tag of the station that will produce it.

A station starts counting its latency once both of its operands hold values. When the count ends it competes for a single result bus. The bus carries a 4-bit producer tag and 64 data bits. Every waiting station whose operand tag matches takes the value. Every register whose status names that tag is written and marked clean. Because a later writer overwrites the status entry, an older in-flight result no longer reaches that register.

The register contents and the bus itself are the block's outputs. The bus serves as the completion trace.

Top module: `tomasulo_core`

## Requirements
- R1: After reset, register k holds the value k, no station is busy, the result bus is idle (`cdb_valid` low) and `iss_ready` is high for every op.
- R2: Op codes are 0 add, 1 subtract, 2 multiply and 3 divide. Ops 0 and 1 use the adder stations (tags 1–3), and ops 2 and 3 use the multiplier stations (tags 4–5). `iss_ready` is high exactly when a station of the op's class is free. An instruction is accepted when `iss_valid` and `iss_ready` are both high, and it takes the lowest free tag of its class.
- R3: At issue, a source whose register status is clear takes the register's value. A source whose status tag is on the bus in that same cycle takes the bus data. Any other source waits on the status tag.
- R4: A station counts only the cycles in which both operands hold values. Its result reaches the bus no earlier than 3 cycles (add/subtract), 11 cycles (multiply) or 41 cycles (divide) after the cycle in which its last operand became available. The issue cycle counts as that cycle when both operands are ready at issue.
- R5: At most one result is on the bus per cycle. Among the finished stations, the one issued earliest drives `cdb_tag` (its tag) and `cdb_data`.
- R6: In the cycle a result is on the bus, every busy station waiting on that tag captures the data for the matching operand(s).
- R7: A register whose status names the bus tag takes the bus data and its status clears. Issuing a later writer to a register replaces that register's status, so the older result no longer writes it.
- R8: A station becomes free at the clock edge that ends its bus cycle. It can be reissued from the next cycle on.
- R9: Results are taken modulo 2^64. Subtract wraps. Multiply keeps the low 64 bits. Divide is unsigned, and a zero divisor gives all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | An instruction is presented |
| iss_op | input | 2 | Op code: 0 add, 1 sub, 2 mul, 3 div |
| iss_dst | input | 3 | Destination register |
| iss_src1 | input | 3 | First source register (dividend / minuend) |
| iss_src2 | input | 3 | Second source register |
| iss_ready | output | 1 | A station of the presented op's class is free |
| cdb_valid | output | 1 | A result is on the bus this cycle |
| cdb_tag | output | 4 | Tag of the station driving the bus |
| cdb_data | output | 64 | Result value on the bus |
| regs | output | 512 | Register file, register k in bits [64k+63:64k] |

## Verification
A behavioural model in the bench keeps its own queue of in-flight instructions in issue order. Each cycle it predicts `iss_ready`, the bus contents and all eight registers. An add result is due on the bus three cycles after its operands are complete, a multiply eleven and a divide forty-one. The result is one cycle later for every earlier finisher that outranks it. A register changes on the edge that ends its bus cycle. The model is advanced once per clock edge with the same inputs as the design. The comparison is made half a clock later, so every expected value is taken in the exact cycle it is due rather than in a window. Directed sequences force a multiply and an add to finish in the same cycle, a full adder class, overwritten destinations and a zero divisor. A pseudo-random stream then exercises same-cycle bus capture at issue.

// File: rtl/tomasulo_core.sv
module tomasulo_core #(
  parameter int XLEN    = 64,
  parameter int NREG    = 8,
  parameter int NADD    = 3,
  parameter int NMUL    = 2,
  parameter int TAGW    = 4,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     iss_valid,
  input  logic [1:0]               iss_op,
  input  logic [$clog2(NREG)-1:0]  iss_dst,
  input  logic [$clog2(NREG)-1:0]  iss_src1,
  input  logic [$clog2(NREG)-1:0]  iss_src2,
  output logic                     iss_ready,
  output logic                     cdb_valid,
  output logic [TAGW-1:0]          cdb_tag,
  output logic [XLEN-1:0]          cdb_data,
  output logic [NREG*XLEN-1:0]     regs
);
  localparam int NST = NADD + NMUL;
  localparam int SW  = $clog2(NST);
  localparam int CW  = $clog2(LAT_DIV + 1);

  logic [NST-1:0]  busy;
  logic [1:0]      op    [NST];
  logic [XLEN-1:0] vj    [NST];
  logic [XLEN-1:0] vk    [NST];
  logic [TAGW-1:0] qj    [NST];
  logic [TAGW-1:0] qk    [NST];
  logic [CW-1:0]   cnt   [NST];
  logic [NST-1:0]  older [NST];
  logic [XLEN-1:0] rf    [NREG];
  logic [TAGW-1:0] st    [NREG];

  logic [NST-1:0]  done, win;
  logic [SW-1:0]   wi, sel;
  logic            fire;
  logic [TAGW-1:0] new_tag, t1, t2, a_q, b_q;
  logic [XLEN-1:0] a_v, b_v;

  function automatic logic [CW-1:0] lat_of(input logic [1:0] o);
    case (o)
      2'd2:    lat_of = CW'(LAT_MUL);
      2'd3:    lat_of = CW'(LAT_DIV);
      default: lat_of = CW'(LAT_ADD);
    endcase
  endfunction

  always_comb begin
    win = '0;
    wi  = '0;
    for (int i = 0; i < NST; i++)
      done[i] = busy[i] && (cnt[i] == lat_of(op[i]));
    for (int i = 0; i < NST; i++)
      if (done[i] && ((older[i] & done) == '0)) begin
        win[i] = 1'b1;
        wi     = SW'(i);
      end
  end

  assign cdb_valid = |done;
  assign cdb_tag   = TAGW'(wi) + TAGW'(1);

  always_comb begin
    case (op[wi])
      2'd0:    cdb_data = vj[wi] + vk[wi];
      2'd1:    cdb_data = vj[wi] - vk[wi];
      2'd2:    cdb_data = vj[wi] * vk[wi];
      default: cdb_data = (vk[wi] == '0) ? '1 : vj[wi] / vk[wi];
    endcase
  end

  always_comb begin
    sel       = '0;
    iss_ready = 1'b0;
    for (int i = NST - 1; i >= 0; i--)
      if (!busy[i] && ((i >= NADD) == iss_op[1])) begin
        sel       = SW'(i);
        iss_ready = 1'b1;
      end
  end

  assign fire    = iss_valid && iss_ready;
  assign new_tag = TAGW'(sel) + TAGW'(1);

  always_comb begin
    t1  = st[iss_src1];
    t2  = st[iss_src2];
    a_v = rf[iss_src1];
    b_v = rf[iss_src2];
    a_q = t1;
    b_q = t2;
    if (t1 != '0 && cdb_valid && t1 == cdb_tag) begin
      a_v = cdb_data;
      a_q = '0;
    end
    if (t2 != '0 && cdb_valid && t2 == cdb_tag) begin
      b_v = cdb_data;
      b_q = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
      for (int i = 0; i < NST; i++) begin
        op[i]    <= '0;
        vj[i]    <= '0;
        vk[i]    <= '0;
        qj[i]    <= '0;
        qk[i]    <= '0;
        cnt[i]   <= '0;
        older[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NST; i++) begin
        if (win[i]) busy[i] <= 1'b0;
        else if (busy[i]) begin
          if (qj[i] == '0 && qk[i] == '0 && cnt[i] < lat_of(op[i]))
            cnt[i] <= cnt[i] + CW'(1);
          if (cdb_valid && qj[i] == cdb_tag) begin
            vj[i] <= cdb_data;
            qj[i] <= '0;
          end
          if (cdb_valid && qk[i] == cdb_tag) begin
            vk[i] <= cdb_data;
            qk[i] <= '0;
          end
        end
        if (fire) older[i][sel] <= 1'b0;
      end
      if (fire) begin
        busy[sel]  <= 1'b1;
        op[sel]    <= iss_op;
        vj[sel]    <= a_v;
        qj[sel]    <= a_q;
        vk[sel]    <= b_v;
        qk[sel]    <= b_q;
        cnt[sel]   <= '0;
        older[sel] <= busy & ~win;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        rf[r] <= XLEN'(r);
        st[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NREG; r++)
        if (cdb_valid && st[r] == cdb_tag) begin
          rf[r] <= cdb_data;
          st[r] <= '0;
        end
      if (fire) st[iss_dst] <= new_tag;
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_regs
    assign regs[r*XLEN +: XLEN] = rf[r];
  end
endmodule

// File: rtl/tomasulo_core_chk.sv
module tomasulo_core_chk #(
  parameter int NST  = 5,
  parameter int NREG = 8,
  parameter int TAGW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iss_valid,
  input logic            iss_ready,
  input logic            cdb_valid,
  input logic [TAGW-1:0] cdb_tag,
  input logic [NST-1:0]  busy,
  input logic [TAGW-1:0] qj [NST],
  input logic [TAGW-1:0] qk [NST],
  input logic [TAGW-1:0] st [NREG]
);
  // R5
  cdb_tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |-> (cdb_tag >= TAGW'(1) && cdb_tag <= TAGW'(NST)));

  // R4
  operands_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |-> (qj[cdb_tag - TAGW'(1)] == '0 && qk[cdb_tag - TAGW'(1)] == '0));

  // R8
  station_freed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |=> !busy[$past(cdb_tag) - TAGW'(1)]);

  // R2
  issue_occupies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && !cdb_valid) |=>
      ($countones(busy) == $past($countones(busy)) + 1));

  // R7
  for (genvar r = 0; r < NREG; r++) begin : g_st
    status_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cdb_valid |=> (st[r] != $past(cdb_tag)));
  end
endmodule

bind tomasulo_core tomasulo_core_chk #(.NST(NADD + NMUL), .NREG(NREG), .TAGW(TAGW)) chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .busy(busy),
  .qj(qj), .qk(qk), .st(st)
);

// File: tb/tomasulo_core_test.sv
`timescale 1ns/1ps
module tomasulo_core_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         iss_valid = 1'b0;
  logic [1:0]   iss_op = '0;
  logic [2:0]   iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
  logic         iss_ready, cdb_valid;
  logic [3:0]   cdb_tag;
  logic [63:0]  cdb_data;
  logic [511:0] regs;

  tomasulo_core uut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .iss_ready(iss_ready), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .cdb_data(cdb_data), .regs(regs)
  );

  always #5 clk = ~clk;

  typedef struct {
    int         tag;
    int         op;
    logic [63:0] av, bv;
    int         at, bt;
    int         cnt;
  } ent_t;

  ent_t        q[$];
  logic [63:0] m_val [8];
  int          m_tag [8];
  int          vectors = 0, fails = 0;
  logic [31:0] lfsr = 32'hACE1_1234;

  function automatic int lat(input int o);
    return (o == 2) ? 10 : (o == 3) ? 40 : 2;
  endfunction

  function automatic logic [63:0] alu(input int o, input logic [63:0] a, input logic [63:0] b);
    case (o)
      0: return a + b;
      1: return a - b;
      2: return a * b;
      default: return (b == 0) ? {64{1'b1}} : a / b;
    endcase
  endfunction

  function automatic int winner();
    foreach (q[i]) if (q[i].cnt == lat(q[i].op)) return i;
    return -1;
  endfunction

  function automatic int free_tag(input int o);
    int lo, hi;
    lo = (o >= 2) ? 4 : 1;
    hi = (o >= 2) ? 5 : 3;
    for (int t = lo; t <= hi; t++) begin
      bit used = 0;
      foreach (q[i]) if (q[i].tag == t) used = 1;
      if (!used) return t;
    end
    return 0;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int w;
    w = winner();
    // R2: ready follows free stations of the op's class
    check("R2 iss_ready", 64'(iss_ready), 64'(free_tag(iss_op) != 0));
    // R5: single oldest finisher on the bus
    check("R5 cdb_valid", 64'(cdb_valid), 64'(w >= 0));
    if (w >= 0) begin
      check("R5 cdb_tag", 64'(cdb_tag), 64'(q[w].tag));
      check("R9 cdb_data", cdb_data, alu(q[w].op, q[w].av, q[w].bv));
    end
    // R7: register contents
    for (int r = 0; r < 8; r++) check("R7 reg", regs[r*64 +: 64], m_val[r]);
  endtask

  task automatic advance(input bit acc, input int o, input int d, input int s1, input int s2);
    int w, bt, nt;
    logic [63:0] bd;
    ent_t n;
    w  = winner();
    bt = (w >= 0) ? q[w].tag : -1;
    bd = (w >= 0) ? alu(q[w].op, q[w].av, q[w].bv) : '0;
    if (acc) begin
      nt = free_tag(o);
      n.tag = nt; n.op = o; n.cnt = 0;
      n.at = m_tag[s1]; n.av = m_val[s1];
      n.bt = m_tag[s2]; n.bv = m_val[s2];
      if (n.at != 0 && n.at == bt) begin n.av = bd; n.at = 0; end
      if (n.bt != 0 && n.bt == bt) begin n.bv = bd; n.bt = 0; end
    end
    foreach (q[i]) if (i != w) begin
      if (q[i].at == 0 && q[i].bt == 0 && q[i].cnt < lat(q[i].op)) q[i].cnt++;
      if (q[i].at == bt) begin q[i].av = bd; q[i].at = 0; end
      if (q[i].bt == bt) begin q[i].bv = bd; q[i].bt = 0; end
    end
    if (w >= 0) q.delete(w);
    for (int r = 0; r < 8; r++)
      if (bt > 0 && m_tag[r] == bt) begin m_val[r] = bd; m_tag[r] = 0; end
    if (acc) begin
      q.push_back(n);
      m_tag[d] = nt;
    end
  endtask

  task automatic step(input bit v, input int o, input int d, input int s1, input int s2, output bit acc);
    iss_valid = v; iss_op = 2'(o); iss_dst = 3'(d); iss_src1 = 3'(s1); iss_src2 = 3'(s2);
    #1;
    compare();
    acc = v && (free_tag(o) != 0);
    advance(acc, o, d, s1, s2);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    bit a;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, a);
  endtask

  task automatic issue(input int o, input int d, input int s1, input int s2);
    bit a;
    a = 0;
    for (int tries = 0; tries < 200 && !a; tries++) step(1, o, d, s1, s2, a);
    iss_valid = 0;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < 8; r++) begin m_val[r] = 64'(r); m_tag[r] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, ready for both classes
    idle(2);
    iss_op = 2'd2; #1; check("R1 ready mul", 64'(iss_ready), 64'd1);
    // R9, R4: add and wrapping subtract from register values
    issue(0, 3, 1, 2);
    issue(1, 4, 1, 2);
    // R3, R6: multiply waits on tag, add chain on multiply result
    issue(2, 5, 3, 7);
    issue(0, 6, 5, 5);
    issue(3, 0, 5, 2);
    idle(60);
    // R2, R8: four adds, the fourth stalls until a station frees
    issue(0, 1, 2, 2);
    issue(0, 2, 3, 3);
    issue(1, 3, 4, 1);
    issue(0, 4, 6, 1);
    idle(10);
    // R7: long divide overtaken by a later writer of the same register
    issue(3, 7, 6, 3);
    issue(0, 7, 1, 1);
    idle(60);
    // R9: divide by zero gives all ones
    issue(1, 2, 1, 1);
    issue(3, 6, 7, 2);
    idle(60);
    // R5: multiply and add finish together, older multiply wins
    issue(2, 1, 1, 1);
    idle(7);
    issue(0, 3, 4, 4);
    idle(20);
    // R3, R6: random stream, includes same-cycle capture at issue
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[15:14] == 2'b00) idle(int'(lfsr[18:16]));
      else issue(int'(lfsr[1:0]) == 3 && lfsr[20] ? 0 : int'(lfsr[1:0]),
                 int'(lfsr[4:2]), int'(lfsr[7:5]), int'(lfsr[10:8]));
    end
    idle(600);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule